// File: doc/BRIEF.md
# Asynchronous Processor-Bus Register Slave

This block lets an external processor read and write a small bank of 8-bit registers held inside a programmable logic device. The processor is the only bus master. It drives a 24-bit byte address and three active-low strobes: device select, read and write. The data lines are eight bits wide and shared. The block drives them only through tri-state outputs with an enable. An acknowledge line, which the block can also float, tells the master when the access has finished.

The strobes come from outside the block's clock domain, so each one passes through a two-flop synchronizer before the handshake state machine acts on it. The acknowledge line is pulled low as soon as a selected access appears on the pins, which holds the master. It goes high only after the read data has been on the bus for at least one local clock, or after the write value has been stored. When the master removes its strobe, the acknowledge and data drivers turn off combinationally, with no clock edge needed.

Each register is one byte but takes up one 32-bit processor word, so neighbouring registers sit four byte addresses apart. The processor reads a full word, and the block drives only the low byte of it.

Top module: `xbus_reg_slave`

## Requirements
- R1: After reset every register reads 0x00. While no access is active, the block drives neither the acknowledge line nor the data lines.
- R2: Register k answers at byte address 4*k. An address maps to a register only if its two low bits are zero and address>>2 is below NUM_REGS (default 4, so the mapped addresses are 0x00, 0x04, 0x08 and 0x0C).
- R3: When select and a strobe are both low on the pins, the acknowledge line is driven low at once, before any clock edge. It stays low until the access completes.
- R4: On a mapped read, the selected register value appears on the data lines at least one local clock before acknowledge is driven high. It stays there while acknowledge is high.
- R5: A mapped write stores the data-line value into the addressed register only. Every other register keeps its value.
- R6: When the master deasserts its strobe or select, acknowledge and the data lines return to high impedance immediately. The block does not start a new access until it has seen the strobes inactive.
- R7: A read of an unmapped address returns 0x00 on the data lines and completes the handshake with acknowledge high.
- R8: A write to an unmapped address changes no register and completes the handshake with acknowledge high.
- R9: Read and write strobes with select held high are ignored. Acknowledge and the data lines stay undriven and no register changes.
- R10: During a write the block never drives the data lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Byte address from the master |
| bus_cs_n | input | 1 | Active-low device select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_data | inout | 8 | Shared data lines, tri-stated when not reading |
| bus_ack | output | 1 | Acknowledge, low while busy, high when done, otherwise floating |

## Verification
The bench plays the master with pull-ups on the shared lines, so a line the block is not driving reads as 0xFF or 1. A block that acknowledged before its read data had settled would fail the check that the correct value was on the bus in the sample before acknowledge rose. A block that kept driving after the strobe fell would fail the check that the lines read as released right after deassertion. Unmapped, misaligned and high addresses must read 0x00 and must not disturb stored values, which catches a decoder that ignores the low address bits or wraps the register index. Strobes with select held high and an overwrite of one register check that nothing leaks into the wrong register.

// File: rtl/xbus_pkg.sv
// Shared types for the processor-bus register slave.
package xbus_pkg;
    // Handshake progress of one bus access
    typedef enum logic [1:0] {
        HS_IDLE     = 2'd0,
        HS_ACK_LOW  = 2'd1,
        HS_ACK_HIGH = 2'd2,
        HS_RELEASE  = 2'd3
    } hs_state_t;
endpackage

// File: rtl/xbus_sync.sv
// Two-flop synchronizer for a vector of asynchronous active-low strobes.
// Assumes each bit is a level that stays put for several clocks. Reset
// loads the inactive (high) level.
module xbus_sync #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    // Two register stages in series to settle metastable inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '1;
            sync_out <= '1;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/xbus_hs_fsm.sv
// Handshake sequencer. It works on synchronized, active-high strobes.
// A selected access with exactly one of read/write moves IDLE -> ACK_LOW.
// ACK_LOW lasts one clock, and in that clock a write pulses its load.
// The FSM then waits in ACK_HIGH until the strobes drop, and passes
// through RELEASE so that it rearms only from an idle bus.
module xbus_hs_fsm
    import xbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_cs,
    input  logic      s_rd,
    input  logic      s_wr,
    output hs_state_t state,
    output logic      is_write,
    output logic      load
);
    hs_state_t nxt;

    // Next-state selection
    always_comb begin
        nxt = state;
        case (state)
            HS_IDLE:     if (s_cs && (s_rd ^ s_wr)) nxt = HS_ACK_LOW;
            HS_ACK_LOW:  nxt = HS_ACK_HIGH;
            HS_ACK_HIGH: if (!(s_cs && (s_rd || s_wr))) nxt = HS_RELEASE;
            default:     nxt = HS_IDLE;
        endcase
    end

    // State and access-direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= HS_IDLE;
            is_write <= 1'b0;
        end else begin
            state <= nxt;
            if (state == HS_IDLE && nxt == HS_ACK_LOW) is_write <= s_wr;
        end
    end

    // Write load fires only in the single ACK_LOW clock
    always_comb load = (state == HS_ACK_LOW) && is_write;

    assert_ack_high_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_ACK_HIGH && $past(state) != HS_ACK_HIGH) |-> $past(state) == HS_ACK_LOW);
    assert_release_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == HS_RELEASE) |=> (state == HS_IDLE));
    assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);
endmodule

// File: rtl/xbus_regbank.sv
// Register bank at a word stride. It decodes the byte address into a
// register index and builds a one-hot load for the addressed register.
// All registers take the same write data. Read data is a mux on the
// index, and an unmapped address returns zero.
module xbus_regbank #(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 8,
    parameter int NUM_REGS  = 4,
    parameter int STRIDE_LG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = ADDR_W - STRIDE_LG;

    logic [IDX_W-1:0]                 idx;
    logic                             mapped;
    logic [NUM_REGS-1:0]              load_vec;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

    // Address decode: aligned word inside the bank
    always_comb begin
        idx    = addr[ADDR_W-1:STRIDE_LG];
        mapped = (addr[STRIDE_LG-1:0] == '0) && (idx < IDX_W'(NUM_REGS));
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        // Per-register load strobe
        assign load_vec[k] = load && mapped && (idx == IDX_W'(k));

        // Storage for one register
        always_ff @(posedge clk) begin
            if (!rst_n)           regs[k] <= '0;
            else if (load_vec[k]) regs[k] <= wdata;
        end
    end

    // Read mux, zero for unmapped offsets
    always_comb begin
        rdata = '0;
        for (int k = 0; k < NUM_REGS; k++)
            if (mapped && idx == IDX_W'(k)) rdata = regs[k];
    end

    assert_load_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec));
    assert_unmapped_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !mapped) |=> $stable(regs));
endmodule

// File: rtl/xbus_reg_slave.sv
// Top of the asynchronous processor-bus register slave.
// It synchronizes the strobes, runs the handshake and drives the
// tri-state pins. Output enables use the raw pins, so the drivers let go
// as soon as the master deasserts. It assumes the master holds address
// and write data steady for the whole strobe.
module xbus_reg_slave
    import xbus_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 8,
    parameter int NUM_REGS  = 4,
    parameter int STRIDE_LG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    inout  wire  [DATA_W-1:0] bus_data,
    output wire               bus_ack
);
    logic [2:0]        strobes_n;
    hs_state_t         state;
    logic              is_write;
    logic              load;
    logic [DATA_W-1:0] rdata;
    logic              raw_access;
    logic              raw_read;
    logic              ack_oe;
    logic              ack_val;
    logic              data_oe;

    xbus_sync #(.WIDTH(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({bus_cs_n, bus_rd_n, bus_wr_n}),
        .sync_out (strobes_n)
    );

    xbus_hs_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_cs     (!strobes_n[2]),
        .s_rd     (!strobes_n[1]),
        .s_wr     (!strobes_n[0]),
        .state    (state),
        .is_write (is_write),
        .load     (load)
    );

    xbus_regbank #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_REGS  (NUM_REGS),
        .STRIDE_LG (STRIDE_LG)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .load  (load),
        .wdata (bus_data),
        .rdata (rdata)
    );

    // Pin-level enables: drop at once when the strobe goes away
    always_comb begin
        raw_access = !bus_cs_n && (!bus_rd_n || !bus_wr_n);
        raw_read   = !bus_cs_n && !bus_rd_n;
        ack_oe     = raw_access && (state != HS_RELEASE);
        ack_val    = (state == HS_ACK_HIGH);
        data_oe    = raw_read && !is_write &&
                     (state == HS_ACK_LOW || state == HS_ACK_HIGH);
    end

    assign bus_ack  = ack_oe  ? ack_val : 1'bz;
    assign bus_data = data_oe ? rdata   : {DATA_W{1'bz}};

    assert_data_before_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state == HS_ACK_HIGH) && !is_write && raw_read && $past(raw_read))
        |-> $past(data_oe));
endmodule

// File: tb/xbus_reg_slave_tb.sv
// Directed bench: models the master and checks the handshake order, the
// bus release and the read-back values.
module xbus_reg_slave_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_cs_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic        tb_drv = 1'b0;
    logic [7:0]  tb_data = '0;
    wire  [7:0]  bus_data;
    wire         bus_ack;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    pullup (bus_ack);
    for (genvar b = 0; b < 8; b++) begin : g_pu
        pullup (bus_data[b]);
    end
    assign bus_data = tb_drv ? tb_data : 8'bzzzz_zzzz;

    xbus_reg_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_cs_n (bus_cs_n),
        .bus_rd_n (bus_rd_n),
        .bus_wr_n (bus_wr_n),
        .bus_data (bus_data),
        .bus_ack  (bus_ack)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // One master access with the handshake order and release checked
    task automatic access(input bit wr, input logic [23:0] a, input logic [7:0] wd,
                          input logic [7:0] exp_rd, input string tag);
        logic [7:0] prev_data;
        bit         acked = 1'b0;
        int         lows = 0;
        @(negedge clk);
        bus_addr = a;
        bus_cs_n = 1'b0;
        if (wr) begin bus_wr_n = 1'b0; tb_drv = 1'b1; tb_data = wd; end
        else bus_rd_n = 1'b0;
        #1;
        check(bus_ack == 1'b0, {"R3 ack low at once ", tag}, 32'(bus_ack), 0);
        prev_data = bus_data;
        for (int i = 0; i < 30 && !acked; i++) begin
            @(negedge clk);
            if (bus_ack == 1'b1) acked = 1'b1;
            else begin
                lows++;
                if (!wr) prev_data = bus_data;
            end
        end
        check(acked && lows >= 2, {"R3 ack low then high ", tag}, 32'(lows), 2);
        if (wr) begin
            check(bus_data == wd, {"R10 write bus not driven by block ", tag},
                  32'(bus_data), 32'(wd));
        end else begin
            check(prev_data == exp_rd, {"R4 data before ack ", tag},
                  32'(prev_data), 32'(exp_rd));
            check(bus_data == exp_rd, {"R4 data with ack ", tag},
                  32'(bus_data), 32'(exp_rd));
        end
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1; tb_drv = 1'b0;
        #1;
        check(bus_ack == 1'b1 && bus_data == 8'hFF, {"R6 release ", tag},
              {23'd0, bus_ack, bus_data}, 32'h1FF);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(bus_ack == 1'b1 && bus_data == 8'hFF, "R1 idle float",
              {23'd0, bus_ack, bus_data}, 32'h1FF);
        for (int k = 0; k < 4; k++) access(1'b0, 24'(4 * k), 8'h00, 8'h00, "R1 reset value");
    endtask

    task automatic t_write_read();
        access(1'b1, 24'h000000, 8'h11, 8'h00, "R5 w0");
        access(1'b1, 24'h000004, 8'h22, 8'h00, "R5 w1");
        access(1'b1, 24'h000008, 8'h5A, 8'h00, "R5 w2");
        access(1'b1, 24'h00000C, 8'hA5, 8'h00, "R5 w3");
        access(1'b0, 24'h000000, 8'h00, 8'h11, "R2 r0");
        access(1'b0, 24'h000004, 8'h00, 8'h22, "R2 r1");
        access(1'b0, 24'h000008, 8'h00, 8'h5A, "R2 r2");
        access(1'b0, 24'h00000C, 8'h00, 8'hA5, "R2 r3");
    endtask

    task automatic t_unmapped();
        access(1'b1, 24'h000010, 8'h77, 8'h00, "R8 write index 4");
        access(1'b1, 24'h000005, 8'h66, 8'h00, "R8 write misaligned");
        access(1'b1, 24'h800004, 8'h44, 8'h00, "R8 write high address");
        access(1'b0, 24'h000010, 8'h00, 8'h00, "R7 read index 4");
        access(1'b0, 24'h000005, 8'h00, 8'h00, "R7 read misaligned");
        access(1'b0, 24'h800004, 8'h00, 8'h00, "R7 read high address");
        access(1'b0, 24'h000004, 8'h00, 8'h22, "R8 r1 intact");
        access(1'b0, 24'h000000, 8'h00, 8'h11, "R8 r0 intact");
    endtask

    task automatic t_cs_high();
        @(negedge clk);
        bus_addr = 24'h000008; bus_rd_n = 1'b0;
        repeat (8) @(negedge clk);
        check(bus_ack == 1'b1 && bus_data == 8'hFF, "R9 read without select",
              {23'd0, bus_ack, bus_data}, 32'h1FF);
        bus_rd_n = 1'b1; bus_wr_n = 1'b0; tb_drv = 1'b1; tb_data = 8'h99;
        repeat (8) @(negedge clk);
        check(bus_ack == 1'b1, "R9 write without select ack", 32'(bus_ack), 1);
        bus_wr_n = 1'b1; tb_drv = 1'b0;
        repeat (6) @(negedge clk);
        access(1'b0, 24'h000008, 8'h00, 8'h5A, "R9 r2 unchanged");
    endtask

    task automatic t_overwrite();
        access(1'b1, 24'h000008, 8'h3C, 8'h00, "R5 overwrite r2");
        access(1'b0, 24'h000008, 8'h00, 8'h3C, "R5 r2 new");
        access(1'b0, 24'h00000C, 8'h00, 8'hA5, "R5 r3 intact");
        access(1'b0, 24'h000004, 8'h00, 8'h22, "R5 r1 intact");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_unmapped();
        t_cs_high();
        t_overwrite();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule